// File: doc/BRIEF.md
# Lockable Security Configuration Register File

This block is a small memory-mapped register bank that stores per-peripheral security attributes and drives them, as static configuration vectors, into the protection controllers of a subsystem. For every peripheral behind an expansion protection controller it keeps a Non-secure access enable and a Secure unprivileged access enable. The two controller classes are a high-performance bus class and a peripheral bus class. It also keeps a set of per-master Non-secure flags and two flags that mark the code and RAM regions as Non-secure callable.

Software configures the bank over a simple 32-bit register bus that carries a transfer size and Secure/privileged attributes. Only full-word Secure privileged traffic can change state. Once the configuration is complete, software sets a sticky lock bit. The lock freezes every security-relevant register until the next reset. Per-bit disable parameters remove unimplemented bits so that they read as zero and cannot be written. The unprivileged-access output for a peripheral is forced low whenever that peripheral is opened to Non-secure access.

Top module: `sec_cfg_regfile`

## Requirements
- R1: A write takes effect only when `size_i` is 2'b10 (word). Byte writes (2'b00), halfword writes (2'b01) and size 2'b11 leave every register unchanged.
- R2: One cycle after `rd_i` is sampled high with `secure_i` and `priv_i` both 1, `rdata_o` holds the addressed register. After any other sampled cycle, including a read without both attributes, `rdata_o` is 0.
- R3: The lock register sits at offset 0x000 and uses bit 0. Writing 1 to that bit sets the lock and writing 0 has no effect. The lock reads back on bit 0 and drives `lock_o`, and only reset clears it.
- R4: While the lock is set, writes to every register other than the lock register are ignored.
- R5: Each expansion controller register holds 16 bits in [15:0], with the upper bits reading 0. Non-secure registers 0..3 sit at 0x010..0x01C for the high-performance class and at 0x020..0x02C for the peripheral class. Secure unprivileged registers 0..3 sit at 0x030..0x03C and 0x040..0x04C. Register k bit n drives bit 16*k+n of the matching output vector, and a value of 1 grants access.
- R6: A bit whose disable parameter bit is 1 always reads 0, ignores writes, and drives 0. The parameters `AHB_DIS` and `APB_DIS` use bit 16*k+n, and `MST_DIS` uses bit n.
- R7: A Secure unprivileged output bit equals its stored bit ANDed with the inverse of the matching Non-secure bit. Readback returns the stored, ungated value.
- R8: The callable-region register sits at 0x004. Bit 1 drives `ram_nsc_o` and bit 0 drives `code_nsc_o`, and all other bits read 0.
- R9: The master Non-secure flags sit at 0x050 bits [31:16] and drive `mst_ns_o`. They reset to 0, so every master is Secure after reset.
- R10: Reads of offsets not listed above return 0, and writes to them change no register.
- R11: A write with `secure_i` or `priv_i` at 0 is ignored.
- R12: All configuration outputs change on the clock edge that samples an accepted write. `rst_ni` low clears every register and `rdata_o` asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Byte offset of the access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| size_i | input | 2 | Transfer size, 2'b10 = word |
| secure_i | input | 1 | Access is Secure |
| priv_i | input | 1 | Access is privileged |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| lock_o | output | 1 | Configuration lock state |
| code_nsc_o | output | 1 | Code region Non-secure callable |
| ram_nsc_o | output | 1 | RAM region Non-secure callable |
| ahb_ns_o | output | 64 | Non-secure enables, high-performance class |
| ahb_sp_o | output | 64 | Gated Secure unprivileged enables, high-performance class |
| apb_ns_o | output | 64 | Non-secure enables, peripheral class |
| apb_sp_o | output | 64 | Gated Secure unprivileged enables, peripheral class |
| mst_ns_o | output | 16 | Per-master Non-secure flags |

## Verification
Every configuration output is a direct register output. A corrupted stored bit therefore shows on the output vectors at the first clock edge after the faulty update, with no masking other than the unprivileged gate. The readback path exposes the ungated stored values one cycle after a read. A bit that the unprivileged gate hides still shows up on the next privileged read. A lock that fails to hold, or a filter that admits a narrow or non-secure write, shows as an output change on the following edge.

// File: rtl/sec_cfg_pkg.sv
package sec_cfg_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOCK,
    SEL_NSC,
    SEL_AHB_NS,
    SEL_APB_NS,
    SEL_AHB_SP,
    SEL_APB_SP,
    SEL_MST
  } sel_e;

  localparam logic [1:0] SIZE_WORD  = 2'b10;
  localparam int unsigned MAX_EXP   = 4;

  // address group = addr[11:4]
  localparam logic [7:0] GRP_CTRL   = 8'h00;
  localparam logic [7:0] GRP_AHB_NS = 8'h01;
  localparam logic [7:0] GRP_APB_NS = 8'h02;
  localparam logic [7:0] GRP_AHB_SP = 8'h03;
  localparam logic [7:0] GRP_APB_SP = 8'h04;
  localparam logic [7:0] GRP_MST    = 8'h05;

endpackage

// File: rtl/sec_cfg_decode.sv
module sec_cfg_decode
  import sec_cfg_pkg::*;
#(
  parameter int unsigned N_EXP = 4
) (
  input  logic [11:0] addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [1:0]  size_i,
  input  logic        secure_i,
  input  logic        priv_i,
  output sel_e        sel_o,
  output logic [1:0]  idx_o,
  output logic        wr_ok_o,
  output logic        rd_ok_o
);

  logic [7:0] grp;
  logic [1:0] word;
  logic       idx_hit;
  logic       attr_ok;

  assign grp     = addr_i[11:4];
  assign word    = addr_i[3:2];
  assign idx_hit = (int'(word) < N_EXP);
  assign idx_o   = word;
  assign attr_ok = secure_i && priv_i;
  assign wr_ok_o = wr_i && attr_ok && (size_i == SIZE_WORD);
  assign rd_ok_o = rd_i && attr_ok;

  always_comb begin
    sel_o = SEL_NONE;
    unique case (grp)
      GRP_CTRL: begin
        if (word == 2'd0)      sel_o = SEL_LOCK;
        else if (word == 2'd1) sel_o = SEL_NSC;
      end
      GRP_AHB_NS: if (idx_hit) sel_o = SEL_AHB_NS;
      GRP_APB_NS: if (idx_hit) sel_o = SEL_APB_NS;
      GRP_AHB_SP: if (idx_hit) sel_o = SEL_AHB_SP;
      GRP_APB_SP: if (idx_hit) sel_o = SEL_APB_SP;
      GRP_MST:    if (word == 2'd0) sel_o = SEL_MST;
      default:    sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/sec_cfg_mask_reg.sv
module sec_cfg_mask_reg #(
  parameter int unsigned W   = 16,
  parameter logic [W-1:0] DIS = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i & ~DIS;
  end

  // disabled bits never hold a 1
  p_dis_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o & DIS) == '0);

endmodule

// File: rtl/sec_cfg_ppc_pair.sv
module sec_cfg_ppc_pair #(
  parameter int unsigned N_EXP = 4,
  parameter int unsigned W     = 16,
  localparam int unsigned VW   = N_EXP * W,
  parameter logic [VW-1:0] DIS = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_i,
  input  logic [N_EXP-1:0] we_ns_i,
  input  logic [N_EXP-1:0] we_sp_i,
  input  logic [W-1:0]  d_i,
  output logic [VW-1:0] ns_o,
  output logic [VW-1:0] sp_raw_o,
  output logic [VW-1:0] sp_o
);

  for (genvar k = 0; k < N_EXP; k++) begin : g_reg
    sec_cfg_mask_reg #(.W(W), .DIS(DIS[k*W +: W])) i_ns (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we_ns_i[k]),
      .d_i    (d_i),
      .q_o    (ns_o[k*W +: W])
    );
    sec_cfg_mask_reg #(.W(W), .DIS(DIS[k*W +: W])) i_sp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we_sp_i[k]),
      .d_i    (d_i),
      .q_o    (sp_raw_o[k*W +: W])
    );
  end

  // unprivileged grant only where the peripheral stays Secure
  assign sp_o = sp_raw_o & ~ns_o;

  p_sp_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_o & sp_o) == '0);

  p_lock_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(ns_o) && $stable(sp_raw_o)));

endmodule

// File: rtl/sec_cfg_regfile.sv
module sec_cfg_regfile
  import sec_cfg_pkg::*;
#(
  parameter int unsigned N_EXP = 4,
  parameter int unsigned EXP_W = 16,
  parameter int unsigned MST_W = 16,
  localparam int unsigned VW   = N_EXP * EXP_W,
  parameter logic [VW-1:0]    AHB_DIS = '0,
  parameter logic [VW-1:0]    APB_DIS = '0,
  parameter logic [MST_W-1:0] MST_DIS = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [11:0]   addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [1:0]    size_i,
  input  logic          secure_i,
  input  logic          priv_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          lock_o,
  output logic          code_nsc_o,
  output logic          ram_nsc_o,
  output logic [VW-1:0] ahb_ns_o,
  output logic [VW-1:0] ahb_sp_o,
  output logic [VW-1:0] apb_ns_o,
  output logic [VW-1:0] apb_sp_o,
  output logic [MST_W-1:0] mst_ns_o
);

  sel_e       sel;
  logic [1:0] idx;
  logic       wr_ok, rd_ok, wr_cfg;
  logic       lock_q;
  logic [1:0] nsc_q;
  logic [VW-1:0] ahb_sp_raw, apb_sp_raw;
  logic [N_EXP-1:0] we_ahb_ns, we_ahb_sp, we_apb_ns, we_apb_sp;
  logic [31:0] rd_val;

  initial begin
    assert (N_EXP >= 1 && N_EXP <= MAX_EXP);
    assert (EXP_W >= 1 && EXP_W <= 16);
    assert (MST_W >= 1 && MST_W <= 16);
  end

  sec_cfg_decode #(.N_EXP(N_EXP)) i_decode (
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .size_i   (size_i),
    .secure_i (secure_i),
    .priv_i   (priv_i),
    .sel_o    (sel),
    .idx_o    (idx),
    .wr_ok_o  (wr_ok),
    .rd_ok_o  (rd_ok)
  );

  // every register except the lock is frozen once locked
  assign wr_cfg = wr_ok && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   lock_q <= 1'b0;
    else if (wr_ok && sel == SEL_LOCK && wdata_i[0]) lock_q <= 1'b1;
  end

  for (genvar k = 0; k < N_EXP; k++) begin : g_we
    logic hit;
    assign hit          = wr_cfg && (int'(idx) == k);
    assign we_ahb_ns[k] = hit && (sel == SEL_AHB_NS);
    assign we_ahb_sp[k] = hit && (sel == SEL_AHB_SP);
    assign we_apb_ns[k] = hit && (sel == SEL_APB_NS);
    assign we_apb_sp[k] = hit && (sel == SEL_APB_SP);
  end

  sec_cfg_mask_reg #(.W(2), .DIS(2'b00)) i_nsc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_cfg && sel == SEL_NSC),
    .d_i    (wdata_i[1:0]),
    .q_o    (nsc_q)
  );

  sec_cfg_mask_reg #(.W(MST_W), .DIS(MST_DIS)) i_mst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_cfg && sel == SEL_MST),
    .d_i    (wdata_i[16 +: MST_W]),
    .q_o    (mst_ns_o)
  );

  sec_cfg_ppc_pair #(.N_EXP(N_EXP), .W(EXP_W), .DIS(AHB_DIS)) i_ahb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (lock_q),
    .we_ns_i  (we_ahb_ns),
    .we_sp_i  (we_ahb_sp),
    .d_i      (wdata_i[EXP_W-1:0]),
    .ns_o     (ahb_ns_o),
    .sp_raw_o (ahb_sp_raw),
    .sp_o     (ahb_sp_o)
  );

  sec_cfg_ppc_pair #(.N_EXP(N_EXP), .W(EXP_W), .DIS(APB_DIS)) i_apb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (lock_q),
    .we_ns_i  (we_apb_ns),
    .we_sp_i  (we_apb_sp),
    .d_i      (wdata_i[EXP_W-1:0]),
    .ns_o     (apb_ns_o),
    .sp_raw_o (apb_sp_raw),
    .sp_o     (apb_sp_o)
  );

  always_comb begin
    rd_val = '0;
    unique case (sel)
      SEL_LOCK:   rd_val[0]           = lock_q;
      SEL_NSC:    rd_val[1:0]         = nsc_q;
      SEL_AHB_NS: rd_val[EXP_W-1:0]   = ahb_ns_o[int'(idx)*EXP_W +: EXP_W];
      SEL_APB_NS: rd_val[EXP_W-1:0]   = apb_ns_o[int'(idx)*EXP_W +: EXP_W];
      SEL_AHB_SP: rd_val[EXP_W-1:0]   = ahb_sp_raw[int'(idx)*EXP_W +: EXP_W];
      SEL_APB_SP: rd_val[EXP_W-1:0]   = apb_sp_raw[int'(idx)*EXP_W +: EXP_W];
      SEL_MST:    rd_val[16 +: MST_W] = mst_ns_o;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_ok ? rd_val : '0;
  end

  assign lock_o     = lock_q;
  assign code_nsc_o = nsc_q[0];
  assign ram_nsc_o  = nsc_q[1];

  p_lock_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  p_lock_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(nsc_q) && $stable(mst_ns_o)));

  p_size_ignore_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_i != SIZE_WORD) |=> ($stable(nsc_q) && $stable(mst_ns_o)
                                       && $stable(ahb_ns_o) && $stable(apb_ns_o)));

  p_attr_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !(secure_i && priv_i)) |=> ($stable(nsc_q) && $stable(mst_ns_o)
                                         && $stable(ahb_ns_o) && $stable(apb_ns_o)));

  p_rd_deny_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && secure_i && priv_i) |=> (rdata_o == '0));

  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel == SEL_NONE) |=> (rdata_o == '0));

endmodule

// File: tb/test_sec_cfg_regfile.sv
module test_sec_cfg_regfile;

  localparam int N_EXP = 4;
  localparam int EXP_W = 16;
  localparam int MST_W = 16;
  localparam int VW    = N_EXP * EXP_W;
  localparam logic [VW-1:0]    AHB_DIS = 64'h00F0_0000_0000_0003;
  localparam logic [VW-1:0]    APB_DIS = 64'h0000_8000_0000_0000;
  localparam logic [MST_W-1:0] MST_DIS = 16'h0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [1:0] size = 2'b10;
  logic sec = 1'b1, priv = 1'b1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic lock, code_nsc, ram_nsc;
  logic [VW-1:0] ahb_ns, ahb_sp, apb_ns, apb_sp;
  logic [MST_W-1:0] mst_ns;

  always #2 clk = ~clk;

  sec_cfg_regfile #(
    .N_EXP(N_EXP), .EXP_W(EXP_W), .MST_W(MST_W),
    .AHB_DIS(AHB_DIS), .APB_DIS(APB_DIS), .MST_DIS(MST_DIS)
  ) i_sec_cfg_regfile (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .size_i(size), .secure_i(sec), .priv_i(priv), .wdata_i(wdata),
    .rdata_o(rdata), .lock_o(lock), .code_nsc_o(code_nsc), .ram_nsc_o(ram_nsc),
    .ahb_ns_o(ahb_ns), .ahb_sp_o(ahb_sp), .apb_ns_o(apb_ns), .apb_sp_o(apb_sp),
    .mst_ns_o(mst_ns)
  );

  // behavioural reference model
  logic        m_lock;
  logic [1:0]  m_nsc;
  logic [15:0] m_ahb_ns [4];
  logic [15:0] m_ahb_sp [4];
  logic [15:0] m_apb_ns [4];
  logic [15:0] m_apb_sp [4];
  logic [15:0] m_mst;
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int w;
    w = int'(a[11:2]);
    if (w == 0) return {31'd0, m_lock};
    if (w == 1) return {30'd0, m_nsc};
    if (w >= 4 && w < 8)   return {16'd0, m_ahb_ns[w-4]};
    if (w >= 8 && w < 12)  return {16'd0, m_apb_ns[w-8]};
    if (w >= 12 && w < 16) return {16'd0, m_ahb_sp[w-12]};
    if (w >= 16 && w < 20) return {16'd0, m_apb_sp[w-16]};
    if (w == 20) return {m_mst, 16'd0};
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = 1'b0; m_nsc = '0; m_mst = '0; m_rdata = '0;
      for (int k = 0; k < 4; k++) begin
        m_ahb_ns[k] = '0; m_ahb_sp[k] = '0; m_apb_ns[k] = '0; m_apb_sp[k] = '0;
      end
    end else begin
      int w;
      m_rdata = (rd && sec && priv) ? m_read(addr) : 32'd0;
      w = int'(addr[11:2]);
      if (wr && sec && priv && size == 2'b10) begin
        if (w == 0) begin
          if (wdata[0]) m_lock = 1'b1;
        end else if (!m_lock) begin
          if (w == 1) m_nsc = wdata[1:0];
          else if (w >= 4 && w < 8)   m_ahb_ns[w-4]  = wdata[15:0] & ~AHB_DIS[(w-4)*16 +: 16];
          else if (w >= 8 && w < 12)  m_apb_ns[w-8]  = wdata[15:0] & ~APB_DIS[(w-8)*16 +: 16];
          else if (w >= 12 && w < 16) m_ahb_sp[w-12] = wdata[15:0] & ~AHB_DIS[(w-12)*16 +: 16];
          else if (w >= 16 && w < 20) m_apb_sp[w-16] = wdata[15:0] & ~APB_DIS[(w-16)*16 +: 16];
          else if (w == 20) m_mst = wdata[31:16] & ~MST_DIS;
        end
      end
    end
  end

  int checks = 0;
  int fails = 0;
  string cur_req = "R12";

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // compare every output against the model on every falling edge
  always @(negedge clk) begin
    logic [VW-1:0] e_ahb_ns, e_ahb_sp, e_apb_ns, e_apb_sp;
    for (int k = 0; k < 4; k++) begin
      e_ahb_ns[k*16 +: 16] = m_ahb_ns[k];
      e_apb_ns[k*16 +: 16] = m_apb_ns[k];
      e_ahb_sp[k*16 +: 16] = m_ahb_sp[k] & ~m_ahb_ns[k];
      e_apb_sp[k*16 +: 16] = m_apb_sp[k] & ~m_apb_ns[k];
    end
    chk("rdata", {32'd0, rdata}, {32'd0, m_rdata});
    chk("lock", {63'd0, lock}, {63'd0, m_lock});
    chk("nsc", {62'd0, ram_nsc, code_nsc}, {62'd0, m_nsc});
    chk("ahb_ns", ahb_ns, e_ahb_ns);
    chk("ahb_sp", ahb_sp, e_ahb_sp);
    chk("apb_ns", apb_ns, e_apb_ns);
    chk("apb_sp", apb_sp, e_apb_sp);
    chk("mst_ns", {48'd0, mst_ns}, {48'd0, m_mst});
  end

  task automatic idle();
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; size = 2'b10; sec = 1'b1; priv = 1'b1;
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d,
                       input logic [1:0] sz = 2'b10, input logic s = 1'b1,
                       input logic p = 1'b1);
    @(negedge clk);
    wr = 1'b1; rd = 1'b0; addr = a; wdata = d; size = sz; sec = s; priv = p;
  endtask

  task automatic do_rd(input logic [11:0] a, input logic s = 1'b1, input logic p = 1'b1);
    @(negedge clk);
    wr = 1'b0; rd = 1'b1; addr = a; size = 2'b10; sec = s; priv = p;
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic read_all();
    for (int w = 0; w < 22; w++) do_rd(12'(w * 4));
    idle();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    cur_req = "R12";           // reset state
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(); idle();

    cur_req = "R5";            // expansion registers, both classes
    for (int k = 0; k < 4; k++) begin
      do_wr(12'h010 + 12'(4*k), 32'hDEAD_A5A0 + 32'(k));
      do_wr(12'h020 + 12'(4*k), 32'h0000_3C30 + 32'(k));
    end
    read_all();

    cur_req = "R6";            // disabled bits read zero
    for (int w = 4; w < 20; w++) do_wr(12'(w * 4), 32'hFFFF_FFFF);
    do_wr(12'h050, 32'hFFFF_FFFF);
    read_all();

    cur_req = "R7";            // unprivileged gating by Non-secure bit
    for (int k = 0; k < 4; k++) begin
      do_wr(12'h010 + 12'(4*k), 32'h0000_00FF << k);
      do_wr(12'h020 + 12'(4*k), 32'h0000_F00F >> k);
    end
    read_all();
    do_wr(12'h014, 32'h0);
    idle(); idle();

    cur_req = "R8";            // callable-region flags
    do_wr(12'h004, 32'hFFFF_FFFD); idle();
    do_wr(12'h004, 32'h0000_0002); idle();
    do_rd(12'h004); idle();
    do_wr(12'h004, 32'h0000_0003); do_rd(12'h004); idle();

    cur_req = "R9";            // master flags in upper half
    do_wr(12'h050, 32'h1234_FFFF); do_rd(12'h050); idle();
    do_wr(12'h050, 32'hFEFE_0000); do_rd(12'h050); idle();

    cur_req = "R1";            // narrow writes ignored
    do_wr(12'h004, 32'h0, 2'b00);
    do_wr(12'h050, 32'h0, 2'b01);
    do_wr(12'h010, 32'h0, 2'b11);
    do_wr(12'h040, 32'h0, 2'b00);
    read_all();

    cur_req = "R11";           // non-secure or unprivileged writes ignored
    do_wr(12'h004, 32'h0, 2'b10, 1'b0, 1'b1);
    do_wr(12'h050, 32'h0, 2'b10, 1'b1, 1'b0);
    do_wr(12'h020, 32'h0, 2'b10, 1'b0, 1'b0);
    do_wr(12'h030, 32'h0, 2'b10, 1'b1, 1'b0);
    read_all();

    cur_req = "R2";            // read filtering
    do_rd(12'h050, 1'b0, 1'b1);
    do_rd(12'h050, 1'b1, 1'b0);
    do_rd(12'h004, 1'b0, 1'b0);
    do_rd(12'h050);
    idle(); idle();

    cur_req = "R10";           // unmapped offsets
    do_wr(12'h008, 32'hFFFF_FFFF);
    do_wr(12'h054, 32'hFFFF_FFFF);
    do_wr(12'h0FC, 32'hFFFF_FFFF);
    do_wr(12'hFFC, 32'hFFFF_FFFF);
    do_rd(12'h008); do_rd(12'h00C); do_rd(12'h054); do_rd(12'h0FC); do_rd(12'hFFC);
    idle();

    cur_req = "R12";           // mixed traffic, lock untouched
    for (int i = 0; i < 3000; i++) begin
      int w;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      w = int'(lfsr[4:0]) % 22;
      if (w == 0) w = 1;
      @(negedge clk);
      addr  = 12'(w * 4);
      wr    = lfsr[5];
      rd    = lfsr[6];
      size  = (lfsr[9:7] == 3'd0) ? lfsr[11:10] : 2'b10;
      sec   = (lfsr[14:12] != 3'd0);
      priv  = (lfsr[17:15] != 3'd0);
      wdata = {lfsr[31:16] ^ lfsr[15:0], lfsr[15:0]};
    end
    idle();

    cur_req = "R3";            // lock set semantics
    do_wr(12'h000, 32'hFFFF_FFFE); do_rd(12'h000); idle();
    do_wr(12'h000, 32'h0000_0001, 2'b01); do_rd(12'h000); idle();
    do_wr(12'h000, 32'h0000_0001); do_rd(12'h000); idle();
    do_wr(12'h000, 32'h0000_0000); do_rd(12'h000); idle();

    cur_req = "R4";            // frozen while locked
    do_wr(12'h004, 32'h0);
    for (int w = 4; w < 20; w++) do_wr(12'(w * 4), 32'(w * 32'h0001_1111));
    do_wr(12'h050, 32'h5555_0000);
    read_all();

    cur_req = "R3";            // only reset clears the lock
    do_reset();
    do_rd(12'h000); idle();
    do_wr(12'h004, 32'h1); do_rd(12'h004); idle(); idle();

    finish_run();
  end

endmodule